// File: doc/BRIEF.md
# Coprocessor Context Save Address Sequencer

This block runs the processor side of a coprocessor context save. On a start pulse it captures a base address and an addressing-mode flag (predecrement or control-alterable). It then reads the coprocessor's 16-bit save-status word once and turns the result into a series of 32-bit memory write requests on a valid/ready interface. The first request always carries the status word. The coprocessor state frame follows as four-byte words pulled from an operand port, stored from the highest frame address down to the lowest.

The status word has two fields. Bits [15:8] hold a code: 0x00 means empty context, 0x01 means "not ready, ask again", 0x02 means a save cannot be taken, and any other value means a frame is present. Bits [7:0] hold the frame size in bytes; the sequencer uses floor(size/4) words. In predecrement mode the whole area (frame plus status word) is reserved below the base address before anything is written. The reduced address is then given back on a writeback output when the sequence ends. The illegal code writes nothing. It aborts the coprocessor and raises a format exception instead.

Top module: `ctx_frame_store`

## Requirements
- R1: After reset the block is idle: no write request, no save-register read, no operand read, and no done, abort, exception or writeback output.
- R2: The save register is read (sav_rd_o high) in the cycle after start_i is sampled. The first write request of every stored sequence carries the status word in data bits [31:16] with bits [15:0] zero.
- R3: In predecrement mode with N = floor(size/4) frame words, the status word goes to base - 4N - 4. When the sequence completes, wb_valid_o pulses together with done_o and wb_addr_o equals that address.
- R4: In control-alterable mode the status word goes to the base address. wb_valid_o stays low.
- R5: Frame words go to F+4N, F+4N-4, ..., F+4 in that order, where F is the status-word address. The addresses step down by exactly 4.
- R6: Each accepted frame write carries the operand-port word present in that cycle, and opr_rd_o pulses exactly once per accepted frame write, so N operand reads occur per save.
- R7: Code 0x02 produces no write request, no done and no writeback. ctl_abort_o and exc_fmt_o pulse together for one cycle, in the cycle after the save read.
- R8: Code 0x00 produces exactly one write (the status word), with no frame words and no operand reads. In predecrement mode the writeback address is base - 4.
- R9: Code 0x01 produces no write. The save register is read again in the very next cycle, and this repeats until another code is returned. The size byte of that code is ignored.
- R10: While wr_valid_o is high and wr_ready_i is low, the request stays asserted with an unchanged address.
- R11: done_o pulses for one cycle in the cycle after the last write is accepted. No further save-register read follows in that save.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a context save (sampled when idle) |
| ea_base_i | input | 32 | Base address from the effective-address descriptor |
| ea_predec_i | input | 1 | 1 = predecrement mode, 0 = control-alterable mode |
| sav_rd_o | output | 1 | Save-status register read strobe |
| sav_word_i | input | 16 | Save-status word returned in the read cycle |
| opr_rd_o | output | 1 | Operand-port read strobe (one per accepted frame word) |
| opr_data_i | input | 32 | Operand-port frame word |
| wr_valid_o | output | 1 | Memory write request valid |
| wr_ready_i | input | 1 | Memory write request accepted |
| wr_addr_o | output | 32 | Memory write address |
| wr_data_o | output | 32 | Memory write data |
| ctl_abort_o | output | 1 | Abort written to the coprocessor control register |
| exc_fmt_o | output | 1 | Format exception request |
| done_o | output | 1 | Save sequence complete |
| wb_valid_o | output | 1 | Updated address-register value is valid |
| wb_addr_o | output | 32 | Updated address-register value (predecrement mode) |

## Verification
The hardest case to reach is a status word that changes between consecutive save-register reads. The come-again retry must loop for several cycles and then go on to a real frame without losing the captured base or mode. The bench answers the first reads of a run with code 0x01, carrying a non-zero size byte, and returns the real word only after a set number of observed read strobes. It then checks the total read count and the full write list. Memory back-pressure on every third cycle is combined with a 53-word frame and with the null code. This exercises held requests in both the status-word and frame phases. A base near zero checks address wraparound in predecrement mode.

// File: rtl/ctx_save_pkg.sv
package ctx_save_pkg;

    localparam int FMT_W  = 16;
    localparam int CODE_W = FMT_W / 2;
    localparam int SIZE_W = FMT_W - CODE_W;
    localparam int NW_W   = SIZE_W - 2;

    localparam logic [CODE_W-1:0] CODE_EMPTY   = 'h00;
    localparam logic [CODE_W-1:0] CODE_AGAIN   = 'h01;
    localparam logic [CODE_W-1:0] CODE_ILLEGAL = 'h02;

    typedef enum logic [1:0] {
        FK_EMPTY,
        FK_AGAIN,
        FK_ILLEGAL,
        FK_FRAME
    } fmt_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SAVRD,
        ST_FMTWR,
        ST_FRMWR,
        ST_FIN,
        ST_ABORT
    } seq_state_e;

    typedef struct packed {
        fmt_kind_e         kind;
        logic [NW_W-1:0]   nwords;
    } fmt_info_t;

    function automatic fmt_kind_e kind_of(input logic [CODE_W-1:0] code);
        unique case (code)
            CODE_EMPTY:   return FK_EMPTY;
            CODE_AGAIN:   return FK_AGAIN;
            CODE_ILLEGAL: return FK_ILLEGAL;
            default:      return FK_FRAME;
        endcase
    endfunction

endpackage

// File: rtl/ctx_fmt_decode.sv
module ctx_fmt_decode
    import ctx_save_pkg::*;
(
    input  logic [FMT_W-1:0] fmt_i,
    output fmt_info_t        info_o
);
    logic [CODE_W-1:0] code;
    logic [SIZE_W-1:0] size;

    assign code = fmt_i[FMT_W-1 -: CODE_W];
    assign size = fmt_i[SIZE_W-1:0];

    always_comb begin
        info_o.kind   = kind_of(code);
        info_o.nwords = (info_o.kind == FK_FRAME) ? size[SIZE_W-1:2] : '0;
    end
endmodule

// File: rtl/ctx_addr_gen.sv
module ctx_addr_gen
    import ctx_save_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cap_i,
    input  logic [AW-1:0]   base_i,
    input  logic            predec_i,
    input  logic            load_i,
    input  logic [NW_W-1:0] nwords_i,
    input  logic            step_i,
    output logic [AW-1:0]   fmt_addr_o,
    output logic [AW-1:0]   frm_addr_o,
    output logic            predec_o
);
    localparam logic [AW-1:0] WORD_BYTES = AW'(4);

    logic [AW-1:0] base_q;
    logic          pre_q;
    logic [AW-1:0] span;
    logic [AW-1:0] new_fmt;

    assign span    = AW'({nwords_i, 2'b00});
    assign new_fmt = pre_q ? (base_q - span - WORD_BYTES) : base_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q     <= '0;
            pre_q      <= 1'b0;
            fmt_addr_o <= '0;
            frm_addr_o <= '0;
        end else begin
            if (cap_i) begin
                base_q <= base_i;
                pre_q  <= predec_i;
            end
            if (load_i) begin
                fmt_addr_o <= new_fmt;
                frm_addr_o <= new_fmt + span;
            end else if (step_i) begin
                frm_addr_o <= frm_addr_o - WORD_BYTES;
            end
        end
    end

    assign predec_o = pre_q;
endmodule

// File: rtl/ctx_save_ctrl.sv
module ctx_save_ctrl
    import ctx_save_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start_i,
    input  fmt_info_t info_i,
    input  logic      wr_ready_i,
    output logic      cap_o,
    output logic      sav_rd_o,
    output logic      load_o,
    output logic      step_o,
    output logic      fmt_phase_o,
    output logic      frm_phase_o,
    output logic      done_o,
    output logic      abort_o
);
    seq_state_e      state_q, state_d;
    logic [NW_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d     = state_q;
        cnt_d       = cnt_q;
        cap_o       = 1'b0;
        sav_rd_o    = 1'b0;
        load_o      = 1'b0;
        step_o      = 1'b0;
        fmt_phase_o = 1'b0;
        frm_phase_o = 1'b0;
        done_o      = 1'b0;
        abort_o     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    cap_o   = 1'b1;
                    state_d = ST_SAVRD;
                end
            end
            ST_SAVRD: begin
                sav_rd_o = 1'b1;
                unique case (info_i.kind)
                    FK_AGAIN:   state_d = ST_SAVRD;
                    FK_ILLEGAL: state_d = ST_ABORT;
                    default: begin
                        load_o  = 1'b1;
                        cnt_d   = info_i.nwords;
                        state_d = ST_FMTWR;
                    end
                endcase
            end
            ST_FMTWR: begin
                fmt_phase_o = 1'b1;
                if (wr_ready_i) state_d = (cnt_q == '0) ? ST_FIN : ST_FRMWR;
            end
            ST_FRMWR: begin
                frm_phase_o = 1'b1;
                if (wr_ready_i) begin
                    step_o = 1'b1;
                    cnt_d  = cnt_q - 1'b1;
                    if (cnt_q == NW_W'(1)) state_d = ST_FIN;
                end
            end
            ST_FIN: begin
                done_o  = 1'b1;
                state_d = ST_IDLE;
            end
            ST_ABORT: begin
                abort_o = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // R9: a come-again answer is followed by another save read
    assert_again_reread_R9: assert property (@(posedge clk) disable iff (rst)
        (sav_rd_o && info_i.kind == FK_AGAIN) |=> sav_rd_o);

    // R7: abort only directly after a save read
    assert_abort_after_read_R7: assert property (@(posedge clk) disable iff (rst)
        abort_o |-> $past(sav_rd_o));
endmodule

// File: rtl/ctx_frame_store.sv
module ctx_frame_store
    import ctx_save_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [AW-1:0]    ea_base_i,
    input  logic             ea_predec_i,
    output logic             sav_rd_o,
    input  logic [FMT_W-1:0] sav_word_i,
    output logic             opr_rd_o,
    input  logic [DW-1:0]    opr_data_i,
    output logic             wr_valid_o,
    input  logic             wr_ready_i,
    output logic [AW-1:0]    wr_addr_o,
    output logic [DW-1:0]    wr_data_o,
    output logic             ctl_abort_o,
    output logic             exc_fmt_o,
    output logic             done_o,
    output logic             wb_valid_o,
    output logic [AW-1:0]    wb_addr_o
);
    localparam int PAD_W = DW - FMT_W;

    fmt_info_t        info;
    logic             cap, load, step, fmt_phase, frm_phase, abort;
    logic [AW-1:0]    fmt_addr, frm_addr;
    logic             predec;
    logic [FMT_W-1:0] fmt_q;

    ctx_fmt_decode u_dec (
        .fmt_i  (sav_word_i),
        .info_o (info)
    );

    ctx_save_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .info_i      (info),
        .wr_ready_i  (wr_ready_i),
        .cap_o       (cap),
        .sav_rd_o    (sav_rd_o),
        .load_o      (load),
        .step_o      (step),
        .fmt_phase_o (fmt_phase),
        .frm_phase_o (frm_phase),
        .done_o      (done_o),
        .abort_o     (abort)
    );

    ctx_addr_gen #(.AW(AW)) u_addr (
        .clk        (clk),
        .rst        (rst),
        .cap_i      (cap),
        .base_i     (ea_base_i),
        .predec_i   (ea_predec_i),
        .load_i     (load),
        .nwords_i   (info.nwords),
        .step_i     (step),
        .fmt_addr_o (fmt_addr),
        .frm_addr_o (frm_addr),
        .predec_o   (predec)
    );

    always_ff @(posedge clk) begin
        if (rst)       fmt_q <= '0;
        else if (load) fmt_q <= sav_word_i;
    end

    assign wr_valid_o  = fmt_phase | frm_phase;
    assign wr_addr_o   = fmt_phase ? fmt_addr : frm_addr;
    assign wr_data_o   = fmt_phase ? {fmt_q, {PAD_W{1'b0}}} : opr_data_i;
    assign opr_rd_o    = frm_phase & wr_ready_i;
    assign ctl_abort_o = abort;
    assign exc_fmt_o   = abort;
    assign wb_valid_o  = done_o & predec;
    assign wb_addr_o   = fmt_addr;

    // R10: a stalled request is held with the same address
    assert_hold_stall_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_addr_o)));

    // R5: consecutive frame writes step down by one word
    assert_descend_R5: assert property (@(posedge clk) disable iff (rst)
        (frm_phase && wr_ready_i) |=> (!frm_phase || wr_addr_o == $past(wr_addr_o) - AW'(4)));

    // R11: completion follows an accepted write
    assert_done_after_write_R11: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(wr_valid_o && wr_ready_i));

    // R3: the writeback appears only at completion
    assert_wb_at_done_R3: assert property (@(posedge clk) disable iff (rst)
        wb_valid_o |-> done_o);

    // R7: no write request while aborting
    assert_abort_no_write_R7: assert property (@(posedge clk) disable iff (rst)
        ctl_abort_o |-> (!wr_valid_o && !done_o));
endmodule

// File: tb/sim_ctx_frame_store.sv
`timescale 1ns/1ps
module sim_ctx_frame_store;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] ea_base_i = '0;
    logic        ea_predec_i = 1'b0;
    logic        sav_rd_o;
    logic [15:0] sav_word_i = '0;
    logic        opr_rd_o;
    logic [31:0] opr_data_i;
    logic        wr_valid_o;
    logic        wr_ready_i = 1'b1;
    logic [31:0] wr_addr_o, wr_data_o;
    logic        ctl_abort_o, exc_fmt_o, done_o, wb_valid_o;
    logic [31:0] wb_addr_o;

    int n_tests = 0;
    int n_fail  = 0;
    logic [15:0] opr_cnt;

    always #2.5 clk = ~clk;

    ctx_frame_store u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .ea_base_i(ea_base_i),
        .ea_predec_i(ea_predec_i), .sav_rd_o(sav_rd_o), .sav_word_i(sav_word_i),
        .opr_rd_o(opr_rd_o), .opr_data_i(opr_data_i), .wr_valid_o(wr_valid_o),
        .wr_ready_i(wr_ready_i), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
        .ctl_abort_o(ctl_abort_o), .exc_fmt_o(exc_fmt_o), .done_o(done_o),
        .wb_valid_o(wb_valid_o), .wb_addr_o(wb_addr_o)
    );

    always @(posedge clk) begin
        if (rst)           opr_cnt <= '0;
        else if (opr_rd_o) opr_cnt <= opr_cnt + 16'd1;
    end
    assign opr_data_i = {16'hDA7A, opr_cnt};

    // {predec, base, status word}
    localparam logic [48:0] VEC [7] = '{
        {1'b0, 32'h0000_1000, 16'h1818},
        {1'b1, 32'h0000_2000, 16'h1818},
        {1'b1, 32'h0000_3000, 16'h41B4},
        {1'b0, 32'h0000_4000, 16'h223B},
        {1'b1, 32'h0000_5000, 16'h0000},
        {1'b0, 32'h0000_6000, 16'h0000},
        {1'b1, 32'h0000_7000, 16'h3CD4}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_save(input bit pre, input logic [31:0] base, input logic [15:0] fmt,
                            input int ca_n, input bit stall);
        bit          illegal = (fmt[15:8] == 8'h02);
        int          nw      = (fmt[15:8] == 8'h00 || illegal) ? 0 : int'(fmt[7:2]);
        logic [31:0] faddr   = pre ? base - 32'(4 * nw) - 32'd4 : base;
        logic [15:0] o0;
        int nrd = 0, nwr = 0, ndone = 0, nabort = 0, nwb = 0, nopr = 0;
        bit fin = 0, prev_stall = 0, first = 1;
        logic [31:0] prev_addr = '0, wb_seen = '0;

        start_i = 1'b1; ea_base_i = base; ea_predec_i = pre;
        @(negedge clk);
        start_i = 1'b0;
        o0 = opr_cnt;
        for (int c = 0; c < 400 && !fin; c++) begin
            wr_ready_i = stall ? ((c % 3) != 0) : 1'b1;
            sav_word_i = (nrd < ca_n) ? 16'h0107 : fmt;
            #1;
            if (first) begin
                chk(sav_rd_o === 1'b1, "R2 read after start", 32'(sav_rd_o), 32'd1);
                first = 0;
            end
            if (prev_stall) begin
                chk(wr_valid_o === 1'b1 && wr_addr_o === prev_addr, "R10 held request", wr_addr_o, prev_addr);
            end
            if (sav_rd_o) nrd++;
            if (opr_rd_o) nopr++;
            if (wr_valid_o && wr_ready_i) begin
                logic [31:0] ea, ed;
                if (nwr == 0) begin
                    ea = faddr; ed = {fmt, 16'h0000};
                    chk(wr_addr_o === ea, "R2/R3/R4 status-word address", wr_addr_o, ea);
                    chk(wr_data_o === ed, "R2 status-word data", wr_data_o, ed);
                end else begin
                    ea = faddr + 32'(4 * nw) - 32'(4 * (nwr - 1));
                    ed = {16'hDA7A, o0 + 16'(nwr - 1)};
                    if (wr_addr_o !== ea) chk(0, "R5 frame address", wr_addr_o, ea);
                    if (wr_data_o !== ed) chk(0, "R6 frame data", wr_data_o, ed);
                end
                nwr++;
            end
            prev_stall = wr_valid_o && !wr_ready_i;
            prev_addr  = wr_addr_o;
            if (ctl_abort_o) begin
                nabort++;
                chk(exc_fmt_o === 1'b1, "R7 exception with abort", 32'(exc_fmt_o), 32'd1);
                fin = 1;
            end
            if (done_o) begin ndone++; fin = 1; end
            if (wb_valid_o) begin nwb++; wb_seen = wb_addr_o; end
            @(negedge clk);
        end
        wr_ready_i = 1'b1;
        chk(fin, "watchdog per save", 32'(fin), 32'd1);
        chk(nwr == (illegal ? 0 : nw + 1), "R5/R8 write count", 32'(nwr), 32'(illegal ? 0 : nw + 1));
        chk(nopr == nw, "R6 operand reads", 32'(nopr), 32'(nw));
        chk(nrd == ca_n + 1, "R9/R11 save reads", 32'(nrd), 32'(ca_n + 1));
        chk(ndone == (illegal ? 0 : 1), "R11 done count", 32'(ndone), 32'(illegal ? 0 : 1));
        chk(nabort == (illegal ? 1 : 0), "R7 abort count", 32'(nabort), 32'(illegal ? 1 : 0));
        chk(nwb == ((pre && !illegal) ? 1 : 0), "R3/R4 writeback count", 32'(nwb), 32'((pre && !illegal) ? 1 : 0));
        if (pre && !illegal) chk(wb_seen === faddr, "R3 writeback address", wb_seen, faddr);
        #1;
        chk(!wr_valid_o && !done_o && !sav_rd_o, "R11 idle after save", 32'(wr_valid_o), 32'd0);
    endtask

    initial begin
        #(5.0 * 200000);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        chk({wr_valid_o, sav_rd_o, opr_rd_o, done_o, ctl_abort_o, exc_fmt_o, wb_valid_o} === 7'b0,
            "R1 reset outputs", 32'({wr_valid_o, sav_rd_o, opr_rd_o, done_o, ctl_abort_o, exc_fmt_o, wb_valid_o}), 32'd0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk(!wr_valid_o && !sav_rd_o, "R1 idle without start", 32'(wr_valid_o), 32'd0);
        @(negedge clk);

        // Table: R3 R4 R5 R6 R8
        for (int i = 0; i < 7; i++) begin
            run_save(VEC[i][48], VEC[i][47:16], VEC[i][15:0], 0, 1'b0);
        end

        // R7: illegal code, predecrement
        run_save(1'b1, 32'h0000_8000, 16'h0218, 0, 1'b0);
        // R7: illegal code, control mode
        run_save(1'b0, 32'h0000_8800, 16'h0200, 0, 1'b0);
        // R9: two come-again answers then a frame
        run_save(1'b1, 32'h0000_9000, 16'h1818, 2, 1'b0);
        // R9: come-again then illegal
        run_save(1'b0, 32'h0000_9800, 16'h0200, 3, 1'b0);
        // R10: back-pressure on frame and null
        run_save(1'b1, 32'h0000_A000, 16'h3CD4, 0, 1'b1);
        run_save(1'b0, 32'h0000_B000, 16'h0000, 0, 1'b1);
        run_save(1'b0, 32'h0000_C000, 16'h1818, 1, 1'b1);
        // R3: predecrement wraparound below zero
        run_save(1'b1, 32'h0000_0008, 16'h1818, 0, 1'b0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule